// File: doc/BRIEF.md
# Interrupt Status Queue

This block gathers interrupt-causing events for a network controller and presents them to a host through a single read-only status port. Three event registers hold flags from the receive path, the transmit path and the buffer manager. Two 10-bit counters, one for missed receive frames and one for transmit collisions, raise an overflow report once they pass their halfway point. The host does not read a flat bitmap. Each read pops one tagged 16-bit word: the low 6 bits name the source register and the high 10 bits carry that register's content. Reporting a source also clears it.

A level interrupt line stays high while any enabled source holds a pending event. Each source has its own enable. A disabled source still latches its events and is reported once it is enabled again. When several sources are pending at once, they are served in a fixed priority order. An event that lands in the same cycle as the read that clears its source is kept.

Top module: `irq_status_queue`

## Requirements
- R1: A status word carries the source tag in bits [5:0] and the source content in bits [15:6]. The tags are 0x04 for receive events, 0x08 for transmit events, 0x0C for buffer events, 0x10 for the miss counter and 0x12 for the collision counter.
- R2: When several enabled sources are pending, reads serve them in the order receive, transmit, buffer, miss counter, collision counter, one source per read.
- R3: A read (`rd_en` high at a clock edge) loads status_word at that same edge with the word of the source it serves and clears that source. status_word holds its value while `rd_en` is low.
- R4: A read made while no enabled source is pending loads status_word with 0x0000 and changes no source.
- R5: `irq` is high after an edge exactly when some source is pending and its bit in `src_en` was set at that edge. It rises at the edge that latches an enabled event and falls at the edge of the read that clears the last enabled pending source.
- R6: A source whose `src_en` bit is 0 still latches its events. It neither raises `irq` nor is served by a read until its bit is set.
- R7: An event strobe ORs its 10 bits into the event register. On the receive source only, an incoming word that has both bit 3 (hashed) and bit 2 (receive OK) set replaces the register content instead, because in that case the upper bits hold a hash index. A source is pending while its content is nonzero.
- R8: Each counter counts one per increment pulse and saturates at 1023. It is pending while its bit 9 is set. Reading it returns its count and resets it to zero.
- R9: An event strobe or counter increment in the same cycle as the read that clears that source is kept. The event register then holds only the new bits, and the counter holds 1.
- R10: After reset, status_word is 0, `irq` is 0 and no source is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_evt_vld | input | 1 | Receive event strobe |
| rx_evt_bits | input | 10 | Receive event flags (bit 3 hashed, bit 2 receive OK) |
| tx_evt_vld | input | 1 | Transmit event strobe |
| tx_evt_bits | input | 10 | Transmit event flags and collision count |
| buf_evt_vld | input | 1 | Buffer event strobe |
| buf_evt_bits | input | 10 | Buffer event flags |
| miss_inc | input | 1 | Missed-frame counter increment |
| col_inc | input | 1 | Collision counter increment |
| src_en | input | 5 | Per-source enable; bit 0 receive through bit 4 collision counter |
| rd_en | input | 1 | Host read strobe; pops one status word |
| status_word | output | 16 | Registered status word of the last read |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
On every cycle the assertions check several properties: `irq` agrees with the pending and enable state, returned tags are legal, status_word is steady between reads, an empty read yields zero, a pending enabled receive source always wins the read, and a counter read with no coincident increment leaves the counter at zero. Some behaviour shows only in the bench scenarios: the exact content of each word, the full priority sequence, OR accumulation against hash-index replacement, saturation at 1023, and events kept across a coincident read. The bench also checks that masked sources stay latched and reappear once enabled.

// File: rtl/isq_pkg.sv
package isq_pkg;
  localparam int ISQ_TAG_W  = 6;
  localparam int ISQ_DATA_W = 10;
  localparam int ISQ_NEVT   = 3;
  localparam int ISQ_NCNT   = 2;
  localparam int ISQ_NSRC   = ISQ_NEVT + ISQ_NCNT;

  // source order is also the service priority, lowest index first
  typedef enum logic [2:0] {
    SRC_RX  = 3'd0,
    SRC_TX  = 3'd1,
    SRC_BUF = 3'd2,
    SRC_MISS = 3'd3,
    SRC_COL = 3'd4
  } isq_src_e;

  function automatic logic [7:0] src_tag(input int idx);
    case (idx)
      0:       src_tag = 8'h04;
      1:       src_tag = 8'h08;
      2:       src_tag = 8'h0C;
      3:       src_tag = 8'h10;
      4:       src_tag = 8'h12;
      default: src_tag = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/isq_event_latch.sv
module isq_event_latch #(
  parameter int DATA_W = 10,
  parameter bit ALT_EN = 1'b0,
  parameter int ALT_A  = 3,
  parameter int ALT_B  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_vld,
  input  logic [DATA_W-1:0] set_bits,
  input  logic              clr,
  output logic [DATA_W-1:0] q,
  output logic              pend,
  output logic              pend_nxt
);
  logic [DATA_W-1:0] base;
  logic [DATA_W-1:0] nxt;

  always_comb begin
    base = clr ? '0 : q;
    nxt  = base;
    if (set_vld) begin
      if (ALT_EN && set_bits[ALT_A] && set_bits[ALT_B]) nxt = set_bits;
      else                                            nxt = base | set_bits;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  assign pend     = |q;
  assign pend_nxt = |nxt;
endmodule

// File: rtl/isq_ovf_counter.sv
module isq_ovf_counter #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  input  logic              clr,
  output logic [DATA_W-1:0] q,
  output logic              pend,
  output logic              pend_nxt
);
  localparam logic [DATA_W-1:0] CNT_MAX = '1;
  logic [DATA_W-1:0] base;
  logic [DATA_W-1:0] nxt;

  always_comb begin
    base = clr ? '0 : q;
    nxt  = (inc && base != CNT_MAX) ? base + 1'b1 : base;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  assign pend     = q[DATA_W-1];
  assign pend_nxt = nxt[DATA_W-1];
endmodule

// File: rtl/isq_arbiter.sv
module isq_arbiter
  import isq_pkg::*;
#(
  parameter int NSRC   = 5,
  parameter int DATA_W = 10,
  parameter int TAG_W  = 6,
  localparam int WORD_W = DATA_W + TAG_W
) (
  input  logic [NSRC-1:0]        req,
  input  logic [NSRC*DATA_W-1:0] content,
  output logic [NSRC-1:0]        grant,
  output logic [WORD_W-1:0]      word
);
  always_comb begin
    grant = '0;
    word  = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        word     = {content[i*DATA_W +: DATA_W], src_tag(i)[TAG_W-1:0]};
      end
    end
  end
endmodule

// File: rtl/irq_status_queue.sv
module irq_status_queue
  import isq_pkg::*;
#(
  parameter int DATA_W = ISQ_DATA_W,
  parameter int TAG_W  = ISQ_TAG_W,
  localparam int WORD_W = DATA_W + TAG_W,
  localparam int NEVT   = ISQ_NEVT,
  localparam int NCNT   = ISQ_NCNT,
  localparam int NSRC   = NEVT + NCNT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_evt_vld,
  input  logic [DATA_W-1:0] rx_evt_bits,
  input  logic              tx_evt_vld,
  input  logic [DATA_W-1:0] tx_evt_bits,
  input  logic              buf_evt_vld,
  input  logic [DATA_W-1:0] buf_evt_bits,
  input  logic              miss_inc,
  input  logic              col_inc,
  input  logic [NSRC-1:0]   src_en,
  input  logic              rd_en,
  output logic [WORD_W-1:0] status_word,
  output logic              irq
);
  logic [NEVT-1:0]        evt_vld;
  logic [DATA_W-1:0]      evt_bits [NEVT];
  logic [NCNT-1:0]        cnt_inc;
  logic [NSRC-1:0]        pend;
  logic [NSRC-1:0]        pend_nxt;
  logic [NSRC-1:0]        grant;
  logic [NSRC-1:0]        clr;
  logic [NSRC*DATA_W-1:0] content;
  logic [WORD_W-1:0]      sel_word;

  assign evt_vld     = {buf_evt_vld, tx_evt_vld, rx_evt_vld};
  assign evt_bits[0] = rx_evt_bits;
  assign evt_bits[1] = tx_evt_bits;
  assign evt_bits[2] = buf_evt_bits;
  assign cnt_inc     = {col_inc, miss_inc};
  assign clr         = rd_en ? grant : '0;

  for (genvar i = 0; i < NEVT; i++) begin : g_evt
    isq_event_latch #(
      .DATA_W(DATA_W),
      .ALT_EN(i == int'(SRC_RX))
    ) u_latch (
      .clk      (clk),
      .rst      (rst),
      .set_vld  (evt_vld[i]),
      .set_bits (evt_bits[i]),
      .clr      (clr[i]),
      .q        (content[i*DATA_W +: DATA_W]),
      .pend     (pend[i]),
      .pend_nxt (pend_nxt[i])
    );
  end

  for (genvar j = 0; j < NCNT; j++) begin : g_cnt
    isq_ovf_counter #(
      .DATA_W(DATA_W)
    ) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .inc      (cnt_inc[j]),
      .clr      (clr[NEVT+j]),
      .q        (content[(NEVT+j)*DATA_W +: DATA_W]),
      .pend     (pend[NEVT+j]),
      .pend_nxt (pend_nxt[NEVT+j])
    );
  end

  isq_arbiter #(
    .NSRC  (NSRC),
    .DATA_W(DATA_W),
    .TAG_W (TAG_W)
  ) u_arb (
    .req     (pend & src_en),
    .content (content),
    .grant   (grant),
    .word    (sel_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_word <= '0;
      irq         <= 1'b0;
    end else begin
      if (rd_en) status_word <= sel_word;
      irq <= |(pend_nxt & src_en);
    end
  end
endmodule

// File: rtl/isq_checker.sv
module isq_checker #(
  parameter int NSRC   = 5,
  parameter int DATA_W = 10,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic              miss_inc,
  input logic [NSRC-1:0]   src_en,
  input logic [NSRC-1:0]   pend,
  input logic [NSRC-1:0]   grant,
  input logic [DATA_W-1:0] miss_cnt,
  input logic [WORD_W-1:0] status_word,
  input logic              irq
);
  // R5: irq tracks enabled pending sources
  a_r5_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq == |(pend & $past(src_en)));

  // R4: empty read returns zero
  a_r4_empty_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (pend & src_en) == '0) |=> status_word == '0);

  // R1: tags are legal
  a_r1_tag_legal: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (status_word[5:0] inside {6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h12}));

  // R3: word holds between reads
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(status_word));

  // R2: receive has top priority
  a_r2_rx_first: assert property (@(posedge clk) disable iff (rst)
    (rd_en && pend[0] && src_en[0]) |=> status_word[5:0] == 6'h04);

  // R8: read counter resets to zero
  a_r8_cnt_clear: assert property (@(posedge clk) disable iff (rst)
    (rd_en && grant[3] && !miss_inc) |=> miss_cnt == '0);

  // R2: one grant at most
  a_r2_grant_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
endmodule

bind irq_status_queue isq_checker #(
  .NSRC  (NSRC),
  .DATA_W(DATA_W),
  .WORD_W(WORD_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rd_en       (rd_en),
  .miss_inc    (miss_inc),
  .src_en      (src_en),
  .pend        (pend),
  .grant       (grant),
  .miss_cnt    (content[3*DATA_W +: DATA_W]),
  .status_word (status_word),
  .irq         (irq)
);

// File: tb/tb_irq_status_queue.sv
`timescale 1ns/1ps
module tb_irq_status_queue;
  logic       clk = 1'b0;
  logic       rst;
  logic       rx_evt_vld, tx_evt_vld, buf_evt_vld;
  logic [9:0] rx_evt_bits, tx_evt_bits, buf_evt_bits;
  logic       miss_inc, col_inc, rd_en;
  logic [4:0] src_en;
  logic [15:0] status_word;
  logic       irq;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [9:0] m_evt [3];
  logic [9:0] m_cnt [2];
  logic [15:0] m_status;
  logic       m_irq;

  always #4 clk = ~clk;

  irq_status_queue dut (
    .clk(clk), .rst(rst),
    .rx_evt_vld(rx_evt_vld), .rx_evt_bits(rx_evt_bits),
    .tx_evt_vld(tx_evt_vld), .tx_evt_bits(tx_evt_bits),
    .buf_evt_vld(buf_evt_vld), .buf_evt_bits(buf_evt_bits),
    .miss_inc(miss_inc), .col_inc(col_inc), .src_en(src_en),
    .rd_en(rd_en), .status_word(status_word), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] m_pend();
    return {m_cnt[1][9], m_cnt[0][9], m_evt[2] != 0, m_evt[1] != 0, m_evt[0] != 0};
  endfunction

  function automatic logic [5:0] m_tag(input int i);
    case (i)
      0: return 6'h04;
      1: return 6'h08;
      2: return 6'h0C;
      3: return 6'h10;
      default: return 6'h12;
    endcase
  endfunction

  task automatic idle_inputs();
    rx_evt_vld = 0; tx_evt_vld = 0; buf_evt_vld = 0;
    rx_evt_bits = 0; tx_evt_bits = 0; buf_evt_bits = 0;
    miss_inc = 0; col_inc = 0; rd_en = 0;
  endtask

  // advance reference by one edge, then compare after the edge
  task automatic tick();
    logic [4:0] req;
    logic [4:0] clr;
    logic [9:0] base;
    logic [15:0] word;
    logic       vld [3];
    logic [9:0] bits [3];
    logic       inc [2];
    req = m_pend() & src_en;
    clr = 0;
    word = 0;
    for (int i = 4; i >= 0; i--)
      if (req[i]) begin
        clr = 0; clr[i] = 1'b1;
        word = {(i < 3) ? m_evt[i] : m_cnt[i-3], m_tag(i)};
      end
    if (!rd_en) clr = 0;
    vld[0] = rx_evt_vld; vld[1] = tx_evt_vld; vld[2] = buf_evt_vld;
    bits[0] = rx_evt_bits; bits[1] = tx_evt_bits; bits[2] = buf_evt_bits;
    inc[0] = miss_inc; inc[1] = col_inc;
    for (int i = 0; i < 3; i++) begin
      base = clr[i] ? 10'h0 : m_evt[i];
      if (vld[i]) begin
        if (i == 0 && bits[i][3] && bits[i][2]) m_evt[i] = bits[i];
        else m_evt[i] = base | bits[i];
      end else m_evt[i] = base;
    end
    for (int j = 0; j < 2; j++) begin
      base = clr[3+j] ? 10'h0 : m_cnt[j];
      m_cnt[j] = (inc[j] && base != 10'h3FF) ? base + 10'h1 : base;
    end
    if (rd_en) m_status = word;
    m_irq = |(m_pend() & src_en);
    @(posedge clk);
    #1;
    chk("R5 irq", {15'h0, irq}, {15'h0, m_irq});
    chk("R3 status", status_word, m_status);
  endtask

  task automatic read_expect(input string req, input logic [15:0] exp);
    rd_en = 1;
    tick();
    rd_en = 0;
    chk(req, status_word, exp);
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    idle_inputs();
    src_en = 0;
    rst = 1;
    for (int i = 0; i < 3; i++) m_evt[i] = 0;
    for (int j = 0; j < 2; j++) m_cnt[j] = 0;
    m_status = 0; m_irq = 0;
    repeat (3) @(posedge clk);
    #1;
    rst = 0;
    chk("R10 reset status", status_word, 16'h0);
    chk("R10 reset irq", {15'h0, irq}, 16'h0);

    // R4: empty read
    src_en = 5'h1F;
    read_expect("R4 empty read", 16'h0000);

    // R1 / R5: transmit event
    src_en = 5'b00010;
    tx_evt_vld = 1; tx_evt_bits = 10'h125;
    tick();
    idle_inputs();
    chk("R5 irq rises", {15'h0, irq}, 16'h1);
    read_expect("R1 tx word", {10'h125, 6'h08});
    chk("R5 irq falls", {15'h0, irq}, 16'h0);

    // R6: masked receive event latched, not served
    src_en = 5'b00000;
    rx_evt_vld = 1; rx_evt_bits = 10'h041;
    tick();
    idle_inputs();
    chk("R6 masked no irq", {15'h0, irq}, 16'h0);
    read_expect("R6 masked not served", 16'h0000);
    src_en = 5'b00001;
    tick();
    chk("R6 enabled irq", {15'h0, irq}, 16'h1);
    read_expect("R6 latched word", {10'h041, 6'h04});

    // R2: priority order
    src_en = 5'h1F;
    rx_evt_vld = 1; rx_evt_bits = 10'h010;
    tx_evt_vld = 1; tx_evt_bits = 10'h004;
    buf_evt_vld = 1; buf_evt_bits = 10'h100;
    tick();
    idle_inputs();
    read_expect("R2 first rx", {10'h010, 6'h04});
    read_expect("R2 second tx", {10'h004, 6'h08});
    read_expect("R2 third buf", {10'h100, 6'h0C});
    read_expect("R2 then empty", 16'h0000);

    // R7: OR accumulate and hash replacement
    buf_evt_vld = 1; buf_evt_bits = 10'h001; tick();
    buf_evt_bits = 10'h200; tick();
    idle_inputs();
    read_expect("R7 or accumulate", {10'h201, 6'h0C});
    rx_evt_vld = 1; rx_evt_bits = 10'h003; tick();
    rx_evt_bits = 10'h2AC; tick();
    idle_inputs();
    read_expect("R7 hash replace", {10'h2AC, 6'h04});

    // R9: event coincident with read of the same source
    buf_evt_vld = 1; buf_evt_bits = 10'h008; tick();
    buf_evt_bits = 10'h004; rd_en = 1; tick();
    idle_inputs();
    chk("R9 old word read", status_word, {10'h008, 6'h0C});
    read_expect("R9 new bits kept", {10'h004, 6'h0C});

    // R8: miss counter overflow at 512
    src_en = 5'b01000;
    miss_inc = 1;
    repeat (511) tick();
    chk("R8 not yet", {15'h0, irq}, 16'h0);
    tick();
    miss_inc = 0;
    chk("R8 overflow irq", {15'h0, irq}, 16'h1);
    read_expect("R8 count word", {10'h200, 6'h10});
    read_expect("R8 cleared", 16'h0000);

    // R8: saturation on a masked collision counter
    src_en = 5'b00000;
    col_inc = 1;
    repeat (1030) tick();
    col_inc = 0;
    src_en = 5'b10000;
    tick();
    read_expect("R8 saturate", {10'h3FF, 6'h12});

    // R9: increment coincident with counter read
    col_inc = 1;
    repeat (512) tick();
    rd_en = 1; tick();
    rd_en = 0;
    chk("R9 cnt read", status_word, {10'h200, 6'h12});
    repeat (510) tick();
    col_inc = 0;
    read_expect("R9 count 511 not pending", 16'h0000);
    col_inc = 1; tick(); col_inc = 0;
    read_expect("R9 coincident inc kept", {10'h200, 6'h12});

    // random mix checked by the reference (R1 R2 R3 R5 R7 R8)
    for (int n = 0; n < 4000; n++) begin
      rx_evt_vld  = ($urandom % 8) == 0;
      rx_evt_bits = 10'($urandom);
      tx_evt_vld  = ($urandom % 8) == 0;
      tx_evt_bits = 10'($urandom);
      buf_evt_vld = ($urandom % 8) == 0;
      buf_evt_bits = 10'($urandom);
      miss_inc    = ($urandom % 2) == 0;
      col_inc     = ($urandom % 2) == 0;
      rd_en       = ($urandom % 4) == 0;
      if (($urandom % 64) == 0) src_en = 5'($urandom);
      tick();
    end
    idle_inputs();
    tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule